// File: doc/BRIEF.md
# Halfword Load and Preload Hint Decoder

This block is one decode stage for the 32-bit compressed-instruction group that holds halfword loads (unsigned and sign-extending) and the data preload hints. Each cycle it may accept one 32-bit instruction word, marked by a valid strobe. One clock later it presents a registered decoded record and a matching valid strobe. The record gives the operation class, the addressing mode, the three register indices, the offset value, the shift amount, and the add, pre-index and writeback flags. It also carries a memory-access flag that downstream stages use to tell real accesses apart from hints that do nothing.

The decoder looks at the base and destination register numbers first. Register 15 in either slot sends the word into the literal space, the preload space or the no-op/undefined space. Words outside those spaces go to the ordinary load space. In that space a pattern test on the six-bit sub-opcode picks the register-offset, unprivileged or indexed form. For the indexed form a three-bit index/add/writeback selector is checked against a fixed set of legal values. The decoder holds no state other than its output register.

Top module: `hlw_decode`

## Requirements
- R1: `out_valid` equals the value `in_valid` had at the previous rising clock edge. The record is captured only in cycles where `in_valid` is high, and it holds otherwise.
- R2: When `rst_n` is low at a rising edge, `out_valid` becomes 0 and every record output becomes 0 at that edge.
- R3: Input fields are op1 = bits 24:23, sub-opcode op2 = bits 11:6, base = bits 19:16, destination = bits 15:12, index register = bits 3:0, wide immediate = bits 11:0, narrow immediate = bits 7:0, shift = bits 5:4, write-intent = bit 21, literal direction = bit 23, and selector = bits 10:8 (index, add, writeback from high to low). Output class codes are 0 unsigned load, 1 signed load, 2 preload, 3 preload-for-write, 4 no-op, 5 undefined. Mode codes are 0 literal, 1 immediate, 2 register, 3 unprivileged.
- R4: When base and destination are both 15, op1 bit 1 set gives class 4, and op1 bit 1 clear gives class 5.
- R5: When base is 15 and destination is not, the result is a literal load: class 1 if op1 bit 1 is set, else class 0. Mode is 0, base output is 15, the offset is the wide immediate, add equals bit 23, pre is 1 and wb is 0.
- R6: When destination is 15 and base is not, op1 = 0 and op2 = 0 give a preload in mode 2 with add = 1 and the shift taken from bits 5:4. op1 = 0 and op2 bits 5:2 = 0xC give a preload in mode 1 with add = 0 and the narrow immediate. op1 = 1 gives a preload in mode 1 with add = 1 and the wide immediate. In every preload, the class is 3 when bit 21 is set and 2 otherwise, and the destination output is 0.
- R7: In the preload space, op1 = 2 with op2 = 0 or op2 bits 5:2 = 0xC gives class 4, op1 = 3 always gives class 4, and any other encoding gives class 5.
- R8: In the load space, op1 = 1 or 3 gives mode 1 with the wide immediate and add = 1. With op1 = 0 or 2 and op2 = 0, the result is mode 2 with the index register and shift. In both cases pre = 1, wb = 0, and the class is 1 when op1 bit 1 is set and 0 otherwise.
- R9: In the load space with op1 = 0 or 2 and op2 bits 5:2 = 0xE, the result is mode 3 with the narrow immediate, add = 1, pre = 1 and wb = 0.
- R10: In the load space with op1 = 0 or 2, no earlier form matched, and either (op2 AND 0x24) = 0x24 or op2 bits 5:2 = 0xC: selector values 1, 3, 4, 5 and 7 give mode 1 with the narrow immediate, pre = selector bit 2, add = selector bit 1, and wb = selector bit 0.
- R11: Any load-space word not matched by R8 to R10 gives class 5. This includes selector values 0, 2 and 6 in the indexed case.
- R12: `out_mem` is 1 exactly for classes 0 to 3. For classes 4 and 5, every record field other than the class is 0, including wb.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Instruction word present this cycle |
| in_insn | input | 32 | Instruction word |
| out_valid | output | 1 | Decoded record present |
| out_cls | output | 3 | Operation class code |
| out_mode | output | 2 | Addressing mode code |
| out_base | output | 4 | Base register index |
| out_dest | output | 4 | Destination register index |
| out_index | output | 4 | Offset register index |
| out_imm | output | 12 | Offset value, zero-extended |
| out_shift | output | 2 | Left shift for register offset |
| out_add | output | 1 | Offset is added (1) or subtracted (0) |
| out_pre | output | 1 | Offset applied before access |
| out_wb | output | 1 | Base register written back |
| out_mem | output | 1 | Record performs a memory access |

## Verification
Every result comes out exactly one clock after the word that caused it, because only the output register lies between the instruction input and the record. The bench drives each word on a falling edge and keeps the model's prediction for that word. On the next falling edge, one full period later and after the capturing rising edge, it compares valid and the whole record against that prediction. The same one-cycle rule applies to reset, which the bench asserts in the middle of traffic so that the cleared record is checked at the same point.

// File: rtl/hlw_pkg.sv
// hlw_pkg: shared widths, field positions, codes and record types for the
// halfword load / preload decoder. Assumes a fixed 32-bit instruction word.
package hlw_pkg;

    localparam int INSN_W   = 32;
    localparam int REG_W    = 4;
    localparam int IMM_W    = 12;
    localparam int NIMM_W   = 8;
    localparam int SH_W     = 2;
    localparam int OP1_W    = 2;
    localparam int OP2_W    = 6;
    localparam int SEL_W    = 3;
    localparam int CLS_W    = 3;
    localparam int MODE_W   = 2;

    // Bit positions the decode depends on
    localparam int OP1_LO   = 23;
    localparam int OP2_LO   = 6;
    localparam int BASE_LO  = 16;
    localparam int DEST_LO  = 12;
    localparam int IDX_LO   = 0;
    localparam int SH_LO    = 4;
    localparam int SEL_LO   = 8;
    localparam int WI_BIT   = 21;
    localparam int DIR_BIT  = 23;

    localparam logic [REG_W-1:0] PC_REG = {REG_W{1'b1}};

    typedef enum logic [CLS_W-1:0] {
        CLS_LDUH  = 3'd0,
        CLS_LDSH  = 3'd1,
        CLS_PLD   = 3'd2,
        CLS_PLDW  = 3'd3,
        CLS_NOP   = 3'd4,
        CLS_UNDEF = 3'd5
    } hw_cls_e;

    typedef enum logic [MODE_W-1:0] {
        AM_LIT = 2'd0,
        AM_IMM = 2'd1,
        AM_REG = 2'd2,
        AM_USR = 2'd3
    } hw_am_e;

    typedef struct packed {
        logic [OP1_W-1:0]  op1;
        logic [OP2_W-1:0]  op2;
        logic [REG_W-1:0]  base;
        logic [REG_W-1:0]  dest;
        logic [REG_W-1:0]  idx;
        logic [IMM_W-1:0]  wimm;
        logic [NIMM_W-1:0] nimm;
        logic [SH_W-1:0]   sh;
        logic              wintent;
        logic              dir;
        logic [SEL_W-1:0]  sel;
    } hw_fields_t;

    typedef struct packed {
        hw_cls_e           cls;
        hw_am_e            mode;
        logic [REG_W-1:0]  base;
        logic [REG_W-1:0]  dest;
        logic [REG_W-1:0]  idx;
        logic [IMM_W-1:0]  imm;
        logic [SH_W-1:0]   sh;
        logic              add;
        logic              pre;
        logic              wb;
        logic              mem;
    } hw_dec_t;

endpackage

// File: rtl/hlw_fields.sv
// hlw_fields: slices an instruction word into its named fields.
// Assumes the fixed field positions in hlw_pkg; purely combinational.
module hlw_fields
    import hlw_pkg::*;
(
    input  logic [INSN_W-1:0] insn,
    output hw_fields_t        f
);

    // Bits not used by this instruction group
    logic unused_bits;
    assign unused_bits = ^{insn[INSN_W-1:OP1_LO+OP1_W], insn[22], insn[20]};

    // Field extraction
    always_comb begin
        f.op1     = insn[OP1_LO  +: OP1_W];
        f.op2     = insn[OP2_LO  +: OP2_W];
        f.base    = insn[BASE_LO +: REG_W];
        f.dest    = insn[DEST_LO +: REG_W];
        f.idx     = insn[IDX_LO  +: REG_W];
        f.wimm    = insn[0       +: IMM_W];
        f.nimm    = insn[0       +: NIMM_W];
        f.sh      = insn[SH_LO   +: SH_W];
        f.wintent = insn[WI_BIT];
        f.dir     = insn[DIR_BIT];
        f.sel     = insn[SEL_LO  +: SEL_W];
    end

endmodule

// File: rtl/hlw_classify.sv
// hlw_classify: turns the extracted fields into a decoded record.
// Assumes nothing beyond the current word; combinational, no state.
// No-op and undefined results carry an all-zero record apart from the class.
module hlw_classify
    import hlw_pkg::*;
(
    input  hw_fields_t f,
    output hw_dec_t    d
);

    logic base_pc, dest_pc;
    logic op2_zero, op2_sub, op2_usr, op2_idx;
    logic sel_ok;

    // Special-register and sub-opcode pattern tests
    always_comb begin
        base_pc  = (f.base == PC_REG);
        dest_pc  = (f.dest == PC_REG);
        op2_zero = (f.op2 == '0);
        op2_sub  = (f.op2[OP2_W-1:2] == 4'hC);
        op2_usr  = (f.op2[OP2_W-1:2] == 4'hE);
        op2_idx  = ((f.op2 & 6'h24) == 6'h24) || op2_sub;
        sel_ok   = (f.sel == 3'd1) || (f.sel == 3'd3) || (f.sel == 3'd4) ||
                   (f.sel == 3'd5) || (f.sel == 3'd7);
    end

    // Space selection and record assembly
    always_comb begin
        d      = '0;
        d.cls  = CLS_UNDEF;
        d.mode = AM_LIT;
        if (base_pc && dest_pc) begin
            d.cls = f.op1[1] ? CLS_NOP : CLS_UNDEF;
        end else if (base_pc) begin
            d.cls  = f.op1[1] ? CLS_LDSH : CLS_LDUH;
            d.mode = AM_LIT;
            d.base = PC_REG;
            d.dest = f.dest;
            d.imm  = f.wimm;
            d.add  = f.dir;
            d.pre  = 1'b1;
            d.mem  = 1'b1;
        end else if (dest_pc) begin
            unique case (f.op1)
                2'd0: begin
                    if (op2_zero) begin
                        d.cls  = f.wintent ? CLS_PLDW : CLS_PLD;
                        d.mode = AM_REG;
                        d.base = f.base;
                        d.idx  = f.idx;
                        d.sh   = f.sh;
                        d.add  = 1'b1;
                        d.pre  = 1'b1;
                        d.mem  = 1'b1;
                    end else if (op2_sub) begin
                        d.cls  = f.wintent ? CLS_PLDW : CLS_PLD;
                        d.mode = AM_IMM;
                        d.base = f.base;
                        d.imm  = {{(IMM_W-NIMM_W){1'b0}}, f.nimm};
                        d.pre  = 1'b1;
                        d.mem  = 1'b1;
                    end
                end
                2'd1: begin
                    d.cls  = f.wintent ? CLS_PLDW : CLS_PLD;
                    d.mode = AM_IMM;
                    d.base = f.base;
                    d.imm  = f.wimm;
                    d.add  = 1'b1;
                    d.pre  = 1'b1;
                    d.mem  = 1'b1;
                end
                2'd2: begin
                    if (op2_zero || op2_sub) d.cls = CLS_NOP;
                end
                default: d.cls = CLS_NOP;
            endcase
        end else begin
            if (f.op1[0]) begin
                d.cls  = f.op1[1] ? CLS_LDSH : CLS_LDUH;
                d.mode = AM_IMM;
                d.base = f.base;
                d.dest = f.dest;
                d.imm  = f.wimm;
                d.add  = 1'b1;
                d.pre  = 1'b1;
                d.mem  = 1'b1;
            end else if (op2_zero) begin
                d.cls  = f.op1[1] ? CLS_LDSH : CLS_LDUH;
                d.mode = AM_REG;
                d.base = f.base;
                d.dest = f.dest;
                d.idx  = f.idx;
                d.sh   = f.sh;
                d.add  = 1'b1;
                d.pre  = 1'b1;
                d.mem  = 1'b1;
            end else if (op2_usr) begin
                d.cls  = f.op1[1] ? CLS_LDSH : CLS_LDUH;
                d.mode = AM_USR;
                d.base = f.base;
                d.dest = f.dest;
                d.imm  = {{(IMM_W-NIMM_W){1'b0}}, f.nimm};
                d.add  = 1'b1;
                d.pre  = 1'b1;
                d.mem  = 1'b1;
            end else if (op2_idx && sel_ok) begin
                d.cls  = f.op1[1] ? CLS_LDSH : CLS_LDUH;
                d.mode = AM_IMM;
                d.base = f.base;
                d.dest = f.dest;
                d.imm  = {{(IMM_W-NIMM_W){1'b0}}, f.nimm};
                d.pre  = f.sel[2];
                d.add  = f.sel[1];
                d.wb   = f.sel[0];
                d.mem  = 1'b1;
            end
        end
    end

endmodule

// File: rtl/hlw_outreg.sv
// hlw_outreg: one-stage output register for the decoded record.
// Assumes synchronous active-low reset; record loads only with a valid word.
module hlw_outreg
    import hlw_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    in_valid,
    input  hw_dec_t d_in,
    output logic    q_valid,
    output hw_dec_t q
);

    // Capture valid every cycle and the record on valid words
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_valid <= 1'b0;
            q       <= '0;
        end else begin
            q_valid <= in_valid;
            if (in_valid) q <= d_in;
        end
    end

endmodule

// File: rtl/hlw_decode.sv
// hlw_decode: top of the halfword load / preload decoder. Field slicing and
// classification are combinational; one register stage drives the outputs.
// Assumes one instruction per cycle and no backpressure.
module hlw_decode
    import hlw_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [INSN_W-1:0]     in_insn,
    output logic                  out_valid,
    output logic [CLS_W-1:0]      out_cls,
    output logic [MODE_W-1:0]     out_mode,
    output logic [REG_W-1:0]      out_base,
    output logic [REG_W-1:0]      out_dest,
    output logic [REG_W-1:0]      out_index,
    output logic [IMM_W-1:0]      out_imm,
    output logic [SH_W-1:0]       out_shift,
    output logic                  out_add,
    output logic                  out_pre,
    output logic                  out_wb,
    output logic                  out_mem
);

    hw_fields_t fields;
    hw_dec_t    dec_c;
    hw_dec_t    dec_q;

    hlw_fields u_fields (
        .insn (in_insn),
        .f    (fields)
    );

    hlw_classify u_classify (
        .f (fields),
        .d (dec_c)
    );

    hlw_outreg u_outreg (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .d_in     (dec_c),
        .q_valid  (out_valid),
        .q        (dec_q)
    );

    // Flatten the registered record onto the ports
    always_comb begin
        out_cls   = dec_q.cls;
        out_mode  = dec_q.mode;
        out_base  = dec_q.base;
        out_dest  = dec_q.dest;
        out_index = dec_q.idx;
        out_imm   = dec_q.imm;
        out_shift = dec_q.sh;
        out_add   = dec_q.add;
        out_pre   = dec_q.pre;
        out_wb    = dec_q.wb;
        out_mem   = dec_q.mem;
    end

endmodule

// File: rtl/hlw_decode_chk.sv
// hlw_decode_chk: property checker for hlw_decode, attached by bind.
// Observes ports only.
module hlw_decode_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        out_valid,
    input logic [2:0]  out_cls,
    input logic [1:0]  out_mode,
    input logic [3:0]  out_base,
    input logic [11:0] out_imm,
    input logic        out_add,
    input logic        out_pre,
    input logic        out_wb,
    input logic        out_mem
);

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);                                              // R1
    AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);                                            // R1
    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_imm == '0 && !out_wb && !out_mem));     // R2
    AST_CLASS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_cls <= 3'd5);                                       // R3
    AST_LITERAL_PC: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_cls <= 3'd1 && out_mode == 2'd0)
        |-> (out_base == 4'hF && out_pre && !out_wb));                        // R5
    AST_REG_NO_IMM: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_mode == 2'd2) |-> out_imm == '0);                   // R8
    AST_USR_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_mode == 2'd3) |-> (out_add && out_pre && !out_wb)); // R9
    AST_WB_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_wb)
        |-> (out_mode == 2'd1 && out_cls <= 3'd1 && out_imm[11:8] == 4'h0));  // R10
    AST_HINT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_cls >= 3'd4)
        |-> (!out_wb && !out_mem && out_base == '0 && out_imm == '0));        // R12
    AST_ACCESS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_cls <= 3'd3) |-> out_mem);                          // R12

endmodule

bind hlw_decode hlw_decode_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_cls   (out_cls),
    .out_mode  (out_mode),
    .out_base  (out_base),
    .out_imm   (out_imm),
    .out_add   (out_add),
    .out_pre   (out_pre),
    .out_wb    (out_wb),
    .out_mem   (out_mem)
);

// File: tb/hlw_decode_test.sv
// hlw_decode_test: behavioural reference model compared every clock.
module hlw_decode_test;

    typedef struct {
        int cls; int mode; int base; int dest; int idx;
        int imm; int sh; int add; int pre; int wb; int mem;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_insn = '0;
    logic        out_valid;
    logic [2:0]  out_cls;
    logic [1:0]  out_mode;
    logic [3:0]  out_base, out_dest, out_index;
    logic [11:0] out_imm;
    logic [1:0]  out_shift;
    logic        out_add, out_pre, out_wb, out_mem;

    int    n_vec = 0;
    int    n_bad = 0;
    bit    done = 0;
    bit    have_exp = 0;
    bit    exp_v = 0;
    bit    exp_rec_chk = 0;
    exp_t  exp_r;
    string exp_tag = "R2";
    bit [31:0] seed = 32'h1234_5678;

    always #10 clk = ~clk;

    hlw_decode uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_insn(in_insn),
        .out_valid(out_valid), .out_cls(out_cls), .out_mode(out_mode),
        .out_base(out_base), .out_dest(out_dest), .out_index(out_index),
        .out_imm(out_imm), .out_shift(out_shift), .out_add(out_add),
        .out_pre(out_pre), .out_wb(out_wb), .out_mem(out_mem)
    );

    // Reference model, written from the requirements
    function automatic void model(input logic [31:0] w, output exp_t e, output string tag);
        int op1 = int'(w[24:23]);
        int op2 = int'(w[11:6]);
        int b   = int'(w[19:16]);
        int t   = int'(w[15:12]);
        int sel = int'(w[10:8]);
        int hi4 = op2 / 4;
        int pcls;
        e = '{default: 0};
        e.cls = 5;
        pcls = w[21] ? 3 : 2;
        if (b == 15 && t == 15) begin
            tag = "R4";
            e.cls = (op1 >= 2) ? 4 : 5;
        end else if (b == 15) begin
            tag = "R5";
            e = '{cls: op1 / 2, mode: 0, base: 15, dest: t, idx: 0, imm: int'(w[11:0]),
                  sh: 0, add: int'(w[23]), pre: 1, wb: 0, mem: 1};
        end else if (t == 15) begin
            if (op1 == 1) begin
                tag = "R6";
                e = '{cls: pcls, mode: 1, base: b, dest: 0, idx: 0, imm: int'(w[11:0]),
                      sh: 0, add: 1, pre: 1, wb: 0, mem: 1};
            end else if (op1 == 0 && op2 == 0) begin
                tag = "R6";
                e = '{cls: pcls, mode: 2, base: b, dest: 0, idx: int'(w[3:0]), imm: 0,
                      sh: int'(w[5:4]), add: 1, pre: 1, wb: 0, mem: 1};
            end else if (op1 == 0 && hi4 == 12) begin
                tag = "R6";
                e = '{cls: pcls, mode: 1, base: b, dest: 0, idx: 0, imm: int'(w[7:0]),
                      sh: 0, add: 0, pre: 1, wb: 0, mem: 1};
            end else begin
                tag = "R7";
                if (op1 == 3 || (op1 == 2 && (op2 == 0 || hi4 == 12))) e.cls = 4;
            end
        end else begin
            int sg = op1 / 2;
            if (op1 % 2 == 1) begin
                tag = "R8";
                e = '{cls: sg, mode: 1, base: b, dest: t, idx: 0, imm: int'(w[11:0]),
                      sh: 0, add: 1, pre: 1, wb: 0, mem: 1};
            end else if (op2 == 0) begin
                tag = "R8";
                e = '{cls: sg, mode: 2, base: b, dest: t, idx: int'(w[3:0]), imm: 0,
                      sh: int'(w[5:4]), add: 1, pre: 1, wb: 0, mem: 1};
            end else if (hi4 == 14) begin
                tag = "R9";
                e = '{cls: sg, mode: 3, base: b, dest: t, idx: 0, imm: int'(w[7:0]),
                      sh: 0, add: 1, pre: 1, wb: 0, mem: 1};
            end else if ((((op2 / 32) % 2 == 1) && ((op2 / 4) % 2 == 1)) || hi4 == 12) begin
                if (sel == 1 || sel == 3 || sel == 4 || sel == 5 || sel == 7) begin
                    tag = "R10";
                    e = '{cls: sg, mode: 1, base: b, dest: t, idx: 0, imm: int'(w[7:0]),
                          sh: 0, add: (sel / 2) % 2, pre: sel / 4, wb: sel % 2, mem: 1};
                end else tag = "R11";
            end else tag = "R11";
        end
    endfunction

    task automatic fld(input string tg, input string nm, input int act, input int ex, inout bit bad);
        if (act != ex) begin
            $display("FAIL %s %s actual=%0d expected=%0d insn=%h", tg, nm, act, ex, in_insn);
            bad = 1;
        end
    endtask

    // Compare outputs against the prediction made one clock earlier
    task automatic compare();
        bit bad = 0;
        if (!have_exp) return;
        n_vec++;
        fld("R1", "valid", int'(out_valid), int'(exp_v), bad);
        if (exp_rec_chk) begin
            fld(exp_tag, "class", int'(out_cls), exp_r.cls, bad);
            fld(exp_tag, "mode", int'(out_mode), exp_r.mode, bad);
            fld("R3", "base", int'(out_base), exp_r.base, bad);
            fld("R3", "dest", int'(out_dest), exp_r.dest, bad);
            fld("R3", "index", int'(out_index), exp_r.idx, bad);
            fld("R3", "imm", int'(out_imm), exp_r.imm, bad);
            fld("R3", "shift", int'(out_shift), exp_r.sh, bad);
            fld(exp_tag, "add", int'(out_add), exp_r.add, bad);
            fld(exp_tag, "pre", int'(out_pre), exp_r.pre, bad);
            fld(exp_tag, "wb", int'(out_wb), exp_r.wb, bad);
            fld("R12", "mem", int'(out_mem), exp_r.mem, bad);
        end
        if (bad) n_bad++;
    endtask

    // One cycle: check previous result, then drive the next word
    task automatic step(input bit rst, input bit v, input logic [31:0] w);
        exp_t  e;
        string tg;
        @(negedge clk);
        compare();
        rst_n    = rst;
        in_valid = v;
        in_insn  = w;
        have_exp = 1;
        if (!rst) begin
            exp_v = 0; exp_rec_chk = 1; exp_r = '{default: 0}; exp_tag = "R2";
        end else if (v) begin
            model(w, e, tg);
            exp_v = 1; exp_rec_chk = 1; exp_r = e; exp_tag = tg;
        end else begin
            exp_v = 0; exp_rec_chk = 0;
        end
    endtask

    function automatic logic [31:0] mk(input int op1, input bit wi, input int b, input int t,
                                       input logic [11:0] lo);
        logic [3:0] bb = b[3:0];
        logic [3:0] tt = t[3:0];
        logic [1:0] oo = op1[1:0];
        return {7'b1111100, oo, 1'b1, wi, 1'b1, bb, tt, lo};
    endfunction

    function automatic bit [31:0] nxt(input bit [31:0] s);
        bit [31:0] x = s;
        x ^= x << 13; x ^= x >> 17; x ^= x << 5;
        return x;
    endfunction

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        // R2: reset with a word offered, record must stay clear
        step(0, 1, mk(1, 0, 2, 3, 12'h123));
        step(0, 1, mk(1, 0, 2, 3, 12'h123));
        // R1: idle then valid
        step(1, 0, 32'h0);
        step(1, 1, mk(1, 0, 2, 3, 12'hABC));       // R8 wide immediate
        step(1, 1, mk(3, 0, 4, 5, 12'hFFF));       // R8 signed wide immediate
        step(1, 1, mk(0, 0, 6, 7, 12'h03A));       // R8 / R3 register form shift 3
        step(1, 1, mk(2, 0, 6, 7, 12'h025));       // R8 signed register form
        step(1, 1, mk(0, 0, 15, 15, 12'h000));     // R4 undefined
        step(1, 1, mk(2, 0, 15, 15, 12'h000));     // R4 no-op
        step(1, 1, mk(0, 0, 15, 1, 12'h456));      // R5 subtract literal
        step(1, 1, mk(3, 0, 15, 1, 12'h456));      // R5 signed add literal
        step(1, 1, mk(0, 1, 9, 15, 12'h01F));      // R6 register preload, write intent
        step(1, 1, mk(0, 0, 9, 15, 12'hC5A));      // R6 subtract narrow
        step(1, 1, mk(1, 1, 9, 15, 12'h777));      // R6 wide add
        step(1, 1, mk(2, 0, 9, 15, 12'h000));      // R7 no-op
        step(1, 1, mk(2, 0, 9, 15, 12'hC00));      // R7 no-op
        step(1, 1, mk(3, 1, 9, 15, 12'h123));      // R7 no-op
        step(1, 1, mk(0, 0, 9, 15, 12'h840));      // R7 undefined
        step(1, 1, mk(2, 0, 9, 15, 12'h100));      // R7 undefined
        step(1, 1, mk(0, 0, 3, 4, 12'hE99));       // R9 unprivileged
        step(1, 1, mk(2, 0, 3, 4, 12'hE01));       // R9 signed unprivileged
        for (int s = 0; s < 8; s++) begin          // R10 / R11 selector sweep
            logic [2:0] sv = s[2:0];
            step(1, 1, mk(0, 0, 5, 6, {1'b1, sv, 8'h5C}));
            step(1, 1, mk(2, 0, 5, 6, {1'b1, sv, 8'hA3}));
        end
        step(1, 1, mk(0, 0, 5, 6, 12'h040));       // R11 unmatched load space
        step(1, 0, mk(1, 0, 2, 3, 12'h111));       // R1 idle holds
        step(0, 1, mk(1, 0, 2, 3, 12'h222));       // R2 reset mid-stream
        step(1, 1, mk(1, 0, 2, 3, 12'h333));
        // Mixed pseudo-random traffic, biased towards special encodings
        for (int k = 0; k < 4000; k++) begin
            bit [31:0] w, c;
            seed = nxt(seed); w = seed;
            seed = nxt(seed); c = seed;
            if (c[1:0] == 2'd0) w[19:16] = 4'hF;
            if (c[3:2] == 2'd0) w[15:12] = 4'hF;
            case (c[6:4])
                3'd0: w[11:6] = 6'd0;
                3'd1: w[11:8] = 4'hC;
                3'd2: w[11:8] = 4'hE;
                3'd3: begin w[11] = 1'b1; w[8] = 1'b1; end
                default: ;
            endcase
            step(c[15:10] != 6'd0, c[9:7] != 3'd0, w);
        end
        step(1, 0, 32'h0);
        step(1, 0, 32'h0);
        done = 1;
        summary();
        $finish;
    end

endmodule